// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads one page table entry from a word-addressed memory port. The upper 20 bits of the address are the virtual page number and the lower 12 bits are the byte offset within a 4 KB page. The entry sits at the table base input plus the page number. The walker captures that address when it accepts a request, so the base input may change between walks.

Once the entry returns, the walker checks it:

- An entry that is not present ends the walk with a page fault.
- An access the entry does not permit ends the walk with a protection fault.
- On a permitted access the walker marks the entry as used, and also as modified if the access is a write. If either mark changed, it writes the entry back to the same word before it answers.
- The answer is a single-cycle response carrying the physical address and two fault flags.

Only one walk is in progress at a time. A new request is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd` and `mem_wr` are 0.
- R2: Each accepted walk issues exactly one single-cycle read at word address `pt_base + req_vaddr[31:12]`, using the `pt_base` value present when the request is accepted.
- R3: The entry word layout is:
  - bit 0: present;
  - bit 1: read allowed;
  - bit 2: write allowed;
  - bit 3: used;
  - bit 4: modified;
  - bits 31:12: frame number.
- R4: On a walk without a fault, `rsp_paddr` equals `{frame, req_vaddr[11:0]}`.
- R5: An entry with bit 0 clear gives `rsp_page_fault`=1 and `rsp_paddr`=0, and the entry is not written.
- R6: A read to an entry with bit 1 clear, or a write to an entry with bit 2 clear, gives `rsp_prot_fault`=1 and `rsp_paddr`=0, and the entry is left unmodified.
- R7: A walk without a fault sets bit 3, and on a write also sets bit 4. When the word changes, it is written once to the same address before `rsp_valid`.
- R8: When the bits from R7 are already set, no write is issued.
- R9: `rsp_valid` lasts one cycle per accepted request. `req_ready` is low from acceptance until the walk ends, and requests presented while busy are ignored.
- R10: A missing entry reports only a page fault, even when its permission bits would also forbid the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Word address where the page table starts |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load access |
| mem_rd | output | 1 | One-cycle read command |
| mem_wr | output | 1 | One-cycle write command |
| mem_addr | output | 32 | Word address for read or write |
| mem_wdata | output | 32 | Updated entry written back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Access not permitted |

## Verification
The walker is driven with five kinds of access, and each separates one decision:

- A load to a fresh entry and then to the same entry again separates the write-back case from the unchanged-entry case.
- A store to that entry, and a second store, do the same for the modified bit.
- Stores to read-only entries and loads to write-only entries show that the protection check reads the correct permission bit for each access kind.
- Missing entries whose permission bits are set show that presence is tested first.
- Accesses at the highest page number under a changed base exercise the full width of the address sum and the frame concatenation.

Memory latency is varied, and requests are held high during a walk, to show that exactly one read is issued and that busy-time requests are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Entry field positions (frame number occupies the top bits)
  localparam int PresentBit = 0;
  localparam int ReadOkBit  = 1;
  localparam int WriteOkBit = 2;
  localparam int UsedBit    = 3;
  localparam int ModBit     = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_CHECK  = 3'd2,
    ST_UPDATE = 3'd3,
    ST_DONE   = 3'd4
  } walk_state_e;
endpackage

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             is_write,
  output logic             page_fault,
  output logic             prot_fault,
  output logic [PTE_W-1:0] new_pte,
  output logic             need_wb,
  output logic [PA_W-1:0]  paddr
);
  import ptw_pkg::*;
  localparam int PFN_W = PA_W - OFF_W;

  function automatic logic [PA_W-1:0] join_frame(input logic [PTE_W-1:0] e,
                                                 input logic [VA_W-1:0] va);
    return {e[PTE_W-1 -: PFN_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [PTE_W-1:0] touch(input logic [PTE_W-1:0] e, input logic wr);
    logic [PTE_W-1:0] t;
    t = e;
    t[UsedBit] = 1'b1;
    if (wr) t[ModBit] = 1'b1;
    return t;
  endfunction

  logic allowed;
  always_comb begin
    allowed    = is_write ? pte[WriteOkBit] : pte[ReadOkBit];
    page_fault = !pte[PresentBit];
    prot_fault = pte[PresentBit] && !allowed;
    new_pte    = touch(pte, is_write);
    need_wb    = !page_fault && !prot_fault && (new_pte != pte);
    paddr      = join_frame(pte, vaddr);
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  rvalid,
  input  logic                  fault,
  input  logic                  need_wb,
  output ptw_pkg::walk_state_e  state,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  load_pte,
  output logic                  rsp_valid,
  output logic                  req_ready
);
  import ptw_pkg::*;
  walk_state_e nxt;
  logic        rd_issued;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_FETCH;
      ST_FETCH:  if (rd_issued && rvalid) nxt = ST_CHECK;
      ST_CHECK:  nxt = (!fault && need_wb) ? ST_UPDATE : ST_DONE;
      ST_UPDATE: nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rd_issued <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_FETCH) rd_issued <= 1'b1;
      else                   rd_issued <= 1'b0;
    end
  end

  assign mem_rd    = (state == ST_FETCH) && !rd_issued;
  assign load_pte  = (state == ST_FETCH) && rd_issued && rvalid;
  assign mem_wr    = (state == ST_UPDATE);
  assign rsp_valid = (state == ST_DONE);
  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  parameter int AW    = 32,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [AW-1:0]    mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_page_fault,
  output logic             rsp_prot_fault
);
  import ptw_pkg::*;
  localparam int VPN_W = VA_W - OFF_W;

  function automatic logic [AW-1:0] entry_of(input logic [AW-1:0] base,
                                             input logic [VA_W-1:0] va);
    return base + AW'(va[VA_W-1:OFF_W]);
  endfunction

  // named internal events, observed by the checker
  logic walk_start, wb_fire, fault_any;

  walk_state_e     state;
  logic            load_pte, page_fault, prot_fault, need_wb;
  logic [VA_W-1:0] vaddr_q;
  logic            wr_q;
  logic [AW-1:0]   entry_q;
  logic [PTE_W-1:0] pte_q, new_pte;
  logic [PA_W-1:0] paddr;

  assign walk_start = req_valid && req_ready;
  assign fault_any  = page_fault || prot_fault;
  assign wb_fire    = mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      wr_q    <= 1'b0;
      entry_q <= '0;
      pte_q   <= '0;
    end else begin
      if (walk_start) begin
        vaddr_q <= req_vaddr;
        wr_q    <= req_write;
        entry_q <= entry_of(pt_base, req_vaddr);
      end
      if (load_pte) pte_q <= mem_rdata;
    end
  end

  ptw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .rvalid(mem_rvalid),
    .fault(fault_any), .need_wb(need_wb), .state(state),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .load_pte(load_pte),
    .rsp_valid(rsp_valid), .req_ready(req_ready)
  );

  ptw_pte_eval #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_eval (
    .pte(pte_q), .vaddr(vaddr_q), .is_write(wr_q),
    .page_fault(page_fault), .prot_fault(prot_fault),
    .new_pte(new_pte), .need_wb(need_wb), .paddr(paddr)
  );

  assign mem_addr       = entry_q;
  assign mem_wdata      = new_pte;
  assign rsp_page_fault = rsp_valid && page_fault;
  assign rsp_prot_fault = rsp_valid && prot_fault;
  assign rsp_paddr      = (rsp_valid && !fault_any) ? paddr : '0;

  if (VPN_W < 1) begin : g_bad_split
    initial $error("offset width must be below address width");
  end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             walk_start,
  input logic             wb_fire,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             rsp_valid,
  input logic             rsp_page_fault,
  input logic             rsp_prot_fault
);
  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7
  wb_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (mem_wdata[0] && mem_wdata[3]));
  // R7
  wb_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> rsp_valid);
  // R5
  no_wb_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> !$past(mem_wr));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);
  // R10
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_page_fault && rsp_prot_fault));
endmodule

bind pt_walker ptw_chk #(.PTE_W(PTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .walk_start(walk_start),
  .wb_fire(wb_fire), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .rsp_valid(rsp_valid), .rsp_page_fault(rsp_page_fault),
  .rsp_prot_fault(rsp_prot_fault)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = 32'h100;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, mem_rd, mem_wr, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rsp_valid, rsp_page_fault, rsp_prot_fault;
  logic [31:0] rsp_paddr;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_page_fault(rsp_page_fault),
    .rsp_prot_fault(rsp_prot_fault)
  );

  int nvec = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [logic [31:0]];
  int          lat = 1, cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr_q = '0, last_rd = '0, last_wr = '0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_wr) begin
      mem[mem_addr] = mem_wdata;
      last_wr = mem_addr;
      wr_cnt++;
    end
    if (mem_rd) begin
      rd_addr_q = mem_addr;
      last_rd = mem_addr;
      cnt = lat;
      rd_cnt++;
    end else if (cnt != 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= peek(rd_addr_q);
      end
    end
  end

  typedef struct {
    logic [31:0] paddr, entry, pte_after;
    bit          pf, prf, wb;
    int          rd0, wr0;
  } exp_t;
  exp_t q[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9 extra response", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_paddr == e.paddr, "R4 paddr", rsp_paddr, e.paddr);
        chk(rsp_page_fault == e.pf, "R5 page fault", 32'(rsp_page_fault), 32'(e.pf));
        chk(rsp_prot_fault == e.prf, "R6 prot fault", 32'(rsp_prot_fault), 32'(e.prf));
        chk(rd_cnt - e.rd0 == 1, "R2 read count", 32'(rd_cnt - e.rd0), 32'd1);
        chk(last_rd == e.entry, "R2 entry address", last_rd, e.entry);
        chk(wr_cnt - e.wr0 == int'(e.wb), "R7 write-back count",
            32'(wr_cnt - e.wr0), 32'(e.wb));
        if (e.wb) chk(last_wr == e.entry, "R7 write-back address", last_wr, e.entry);
        chk(peek(e.entry) == e.pte_after, "R7 entry after walk",
            peek(e.entry), e.pte_after);
      end
    end
  end

  // driver: expected values from R3..R8, R10
  task automatic walk(input logic [31:0] va, input bit wr, input bit poke);
    exp_t        e;
    logic [31:0] pte;
    e.entry = pt_base + {12'h0, va[31:12]};
    pte = peek(e.entry);
    e.pf = 0; e.prf = 0; e.wb = 0; e.paddr = '0; e.pte_after = pte;
    if (!pte[0]) e.pf = 1;                       // R10: presence first
    else if (wr ? !pte[2] : !pte[1]) e.prf = 1;
    else begin
      e.paddr = {pte[31:12], va[11:0]};
      e.pte_after = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
      e.wb = (e.pte_after != pte);
    end
    e.rd0 = rd_cnt; e.wr0 = wr_cnt;
    q.push_back(e);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    if (poke) begin
      req_vaddr = 32'hABCDE123; req_write = ~wr;  // R9: ignored while busy
      do @(negedge clk); while (!rsp_valid);
      req_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
      do @(negedge clk); while (!rsp_valid);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        nvec++; nfail++;
        $display("FAIL watchdog actual=%0d expected=<100000", wd);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
      end
    end
  end

  initial begin
    // R3 layout: [0]present [1]read [2]write [3]used [4]modified [31:12]frame
    mem[32'h110] = 32'h00022007;
    mem[32'h111] = 32'h00045003;
    mem[32'h112] = 32'h00078006;
    mem[32'h114] = 32'h00099005;
    mem[32'h104FFF] = 32'hFFFFF007;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd == 1'b0, "R1 mem_rd", 32'(mem_rd), 32'd0);
    chk(mem_wr == 1'b0, "R1 mem_wr", 32'(mem_wr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    walk(32'h00010020, 0, 0);   // R4 R7 first use sets used bit
    walk(32'h00010abc, 0, 0);   // R8 used already set
    lat = 3;
    walk(32'h00010ffc, 1, 0);   // R7 store sets modified
    walk(32'h00010000, 1, 0);   // R8 both already set
    walk(32'h00011044, 1, 0);   // R6 store to read-only
    walk(32'h00011044, 0, 0);   // R4 load from read-only
    lat = 7;
    walk(32'h00012010, 1, 0);   // R5 R10 missing entry with permissions
    walk(32'h00013000, 0, 0);   // R5 zero entry
    walk(32'h00014008, 0, 0);   // R6 load from write-only
    walk(32'h00014008, 1, 1);   // R7 R9 store with busy-time requests
    lat = 2;
    pt_base = 32'h5000;
    walk(32'hFFFFFFFF, 1, 0);   // R2 R4 highest page, new base
    walk(32'hFFFFF000, 0, 1);   // R9 R8
    chk(q.size() == 0, "R9 responses outstanding", 32'(q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule